// File: doc/BRIEF.md
# Linked-List DMA Descriptor Fetcher

This block serves one DMA channel that walks a chain of descriptors held in memory. When the channel engine asks for the next descriptor, the fetcher takes the descriptor pointer and reads four consecutive 32-bit words from it, one at a time, over a memory read port with a valid/ready request and a response valid. The first word is a control word carrying an end-of-list bit, four transfer flags and a total-size field. The next two words are the source and destination addresses, and the last is the pointer to the following descriptor.

Once the fourth word returns, the block pulses a one-cycle completion strobe. It presents all decoded fields on registered outputs, ready to be loaded into the channel registers. These are the flags, the size, both addresses, the address of the descriptor just read, the new descriptor pointer, and a flag that says whether another descriptor follows. The outputs hold their values until the next fetch completes.

The block also keeps the channel's size field. It is loaded from each fetched descriptor. At final termination, when size write-back and descriptor mode are both enabled, it is replaced by the remaining word count.

Top module: `desc_fetch_top`

## Requirements
- R1: On synchronous reset, and after a reset applied during a fetch, busy_o, done_o and rd_valid_o are low, and all field outputs and size_o are zero.
- R2: A start sampled while idle latches desc_ptr_i. The four reads are issued strictly in order at byte offsets 0x0, 0x4, 0x8 and 0xC from that pointer. Only one read is outstanding at a time, and the next request is raised only after the previous response.
- R3: While rd_valid_o is high and rd_ready_i is low, rd_valid_o stays high and rd_addr_o does not change.
- R4: done_o is high for exactly one cycle, in the cycle right after the fourth response is sampled. busy_o is low in that cycle.
- R5: more_o is the inverse of bit 20 (end-of-list) of the control word.
- R6: flags_o equals control word bits 19:16. Bit 16 is source increment, bit 17 destination increment, bit 18 source select and bit 19 destination select. All other control bits besides these, bit 20 and bits 11:0 have no effect.
- R7: size_o takes control word bits 11:0 (total size in words) when a fetch completes.
- R8: src_addr_o takes the word at offset 0x4 and dst_addr_o the word at offset 0x8.
- R9: cur_desc_o takes the pointer the fetch started from, and next_desc_o takes the word at offset 0xC.
- R10: A start while a fetch is running is ignored. The fetch keeps its pointer and issues exactly four reads.
- R11: A term_i pulse with wb_size_i and desc_mode_i both high sets size_o to its previous value minus words_done_i one cycle later. If either of them is low, size_o is unchanged.
- R12: The field outputs and size_o do not change while a fetch is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to fetch one descriptor |
| desc_ptr_i | input | ADDR_W | Address of the descriptor to fetch |
| rd_valid_o | output | 1 | Read request valid |
| rd_addr_o | output | ADDR_W | Read request byte address |
| rd_ready_i | input | 1 | Memory accepts the read request |
| rsp_valid_i | input | 1 | Read data valid |
| rsp_data_i | input | DATA_W | Read data |
| busy_o | output | 1 | A fetch is in progress |
| done_o | output | 1 | One-cycle strobe: descriptor fields are ready |
| more_o | output | 1 | Another descriptor follows in the chain |
| flags_o | output | 4 | Transfer flags from the control word |
| src_addr_o | output | ADDR_W | Source address |
| dst_addr_o | output | ADDR_W | Destination address |
| cur_desc_o | output | ADDR_W | Address of the descriptor just fetched |
| next_desc_o | output | ADDR_W | New descriptor pointer |
| size_o | output | 12 | Channel total-size field |
| term_i | input | 1 | Final termination strobe from the engine |
| wb_size_i | input | 1 | Size write-back enabled |
| desc_mode_i | input | 1 | Channel runs in descriptor mode |
| words_done_i | input | 12 | Words transferred at termination |

## Verification
The first read request is due in the cycle after start is sampled. Each further request is due in the cycle after the previous response is sampled, done_o is due in the cycle after the fourth response, and a size write-back shows on size_o in the cycle after term_i. The bench drives and samples only on the falling clock edge. It keeps a cycle counter, so it can compare the cycle in which done_o appears with the cycle of the last response exactly. It logs every accepted request address in order, and it watches the field outputs on every busy cycle. Stimulus vectors vary the memory latency and the request stall length, so these timings are checked under several handshake patterns.

// File: rtl/desc_fetch_pkg.sv
package desc_fetch_pkg;
  localparam int NWORDS     = 4;   // control, source, destination, next
  localparam int WORD_BYTES = 4;
  localparam int EOL_BIT    = 20;
  localparam int FLG_LSB    = 16;
  localparam int FLG_W      = 4;
  localparam int TSZ_W      = 12;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT
  } fetch_state_t;
endpackage

// File: rtl/desc_fetch_seq.sv
module desc_fetch_seq
  import desc_fetch_pkg::*;
#(
  parameter int ADDR_W = 32,
  localparam int IDXW  = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic              rd_ready_i,
  input  logic              rsp_valid_i,
  output logic              rd_valid_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              busy_o,
  output logic              cap_o,
  output logic              fin_o,
  output logic [IDXW-1:0]   idx_o,
  output logic [ADDR_W-1:0] base_o,
  output logic              done_o
);
  localparam logic [IDXW-1:0]   LAST_IDX = IDXW'(NWORDS - 1);
  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(WORD_BYTES);

  fetch_state_t      state_q;
  logic [IDXW-1:0]   idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] base_q;
  logic              done_q;

  assign cap_o      = (state_q == ST_WAIT) && rsp_valid_i;
  assign fin_o      = cap_o && (idx_q == LAST_IDX);
  assign busy_o     = (state_q != ST_IDLE);
  assign rd_valid_o = (state_q == ST_REQ);
  assign rd_addr_o  = addr_q;
  assign idx_o      = idx_q;
  assign base_o     = base_q;
  assign done_o     = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      addr_q  <= '0;
      base_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            base_q  <= ptr_i;
            addr_q  <= ptr_i;
            idx_q   <= '0;
            state_q <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (rd_ready_i) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rsp_valid_i) begin
            if (idx_q == LAST_IDX) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              idx_q   <= idx_q + 1'b1;
              addr_q  <= addr_q + STEP;
              state_q <= ST_REQ;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3: a stalled request keeps its address
  p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_addr_o)));

  // R2: one outstanding read; no new request right after acceptance
  p_one_outstanding_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_valid_o && rd_ready_i) |=> !rd_valid_o);

  // R10: a start during a fetch leaves the latched pointer alone
  p_no_restart_r10: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> $stable(base_o));

  // R4: done is a single-cycle strobe
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
endmodule

// File: rtl/desc_fetch_decode.sv
module desc_fetch_decode
  import desc_fetch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int IDXW  = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_i,
  input  logic              fin_i,
  input  logic [IDXW-1:0]   idx_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [TSZ_W-1:0]  stage_tsz_o,
  output logic              more_o,
  output logic [FLG_W-1:0]  flags_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [ADDR_W-1:0] next_o,
  output logic [ADDR_W-1:0] cur_o
);
  localparam logic [IDXW-1:0] IDX_CTRL = IDXW'(0);
  localparam logic [IDXW-1:0] IDX_SRC  = IDXW'(1);
  localparam logic [IDXW-1:0] IDX_DST  = IDXW'(2);

  logic              s_more;
  logic [FLG_W-1:0]  s_flg;
  logic [TSZ_W-1:0]  s_tsz;
  logic [ADDR_W-1:0] s_src;
  logic [ADDR_W-1:0] s_dst;

  assign stage_tsz_o = s_tsz;

  // Staging: words arrive one at a time and wait for the last one
  always_ff @(posedge clk) begin
    if (rst) begin
      s_more <= 1'b0;
      s_flg  <= '0;
      s_tsz  <= '0;
      s_src  <= '0;
      s_dst  <= '0;
    end else if (cap_i) begin
      if (idx_i == IDX_CTRL) begin
        s_more <= ~data_i[EOL_BIT];
        s_flg  <= data_i[FLG_LSB +: FLG_W];
        s_tsz  <= data_i[TSZ_W-1:0];
      end
      if (idx_i == IDX_SRC) s_src <= data_i[ADDR_W-1:0];
      if (idx_i == IDX_DST) s_dst <= data_i[ADDR_W-1:0];
    end
  end

  // Presented fields change only when the fetch completes
  always_ff @(posedge clk) begin
    if (rst) begin
      more_o  <= 1'b0;
      flags_o <= '0;
      src_o   <= '0;
      dst_o   <= '0;
      next_o  <= '0;
      cur_o   <= '0;
    end else if (fin_i) begin
      more_o  <= s_more;
      flags_o <= s_flg;
      src_o   <= s_src;
      dst_o   <= s_dst;
      next_o  <= data_i[ADDR_W-1:0];
      cur_o   <= base_i;
    end
  end

  // R12: fields hold between completions
  p_fields_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !fin_i |=> ($stable(src_o) && $stable(dst_o) && $stable(next_o) && $stable(flags_o)));

  // R9: the next pointer is the word that completed the fetch
  p_next_word_r9: assert property (@(posedge clk) disable iff (rst)
    fin_i |=> (next_o == $past(data_i[ADDR_W-1:0])));
endmodule

// File: rtl/desc_fetch_size.sv
module desc_fetch_size
  import desc_fetch_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [TSZ_W-1:0] load_val_i,
  input  logic             term_i,
  input  logic             wb_size_i,
  input  logic             desc_mode_i,
  input  logic [TSZ_W-1:0] words_done_i,
  output logic [TSZ_W-1:0] size_o
);
  logic wb_fire;
  assign wb_fire = term_i && wb_size_i && desc_mode_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      size_o <= '0;
    end else if (load_i) begin
      size_o <= load_val_i;
    end else if (wb_fire) begin
      size_o <= size_o - words_done_i;
    end
  end

  // R11: remaining count written back at termination
  p_writeback_r11: assert property (@(posedge clk) disable iff (rst)
    (term_i && wb_size_i && desc_mode_i && !load_i) |=> (size_o == $past(size_o) - $past(words_done_i)));

  // R11: write-back gated by both enables
  p_wb_gated_r11: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !(wb_size_i && desc_mode_i)) |=> $stable(size_o));
endmodule

// File: rtl/desc_fetch_top.sv
module desc_fetch_top
  import desc_fetch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] desc_ptr_i,
  output logic              rd_valid_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ready_i,
  input  logic              rsp_valid_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              more_o,
  output logic [FLG_W-1:0]  flags_o,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic [ADDR_W-1:0] dst_addr_o,
  output logic [ADDR_W-1:0] cur_desc_o,
  output logic [ADDR_W-1:0] next_desc_o,
  output logic [TSZ_W-1:0]  size_o,
  input  logic              term_i,
  input  logic              wb_size_i,
  input  logic              desc_mode_i,
  input  logic [TSZ_W-1:0]  words_done_i
);
  localparam int IDXW = $clog2(NWORDS);

  logic              cap;
  logic              fin;
  logic [IDXW-1:0]   idx;
  logic [ADDR_W-1:0] base;
  logic [TSZ_W-1:0]  stage_tsz;

  desc_fetch_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .ptr_i      (desc_ptr_i),
    .rd_ready_i (rd_ready_i),
    .rsp_valid_i(rsp_valid_i),
    .rd_valid_o (rd_valid_o),
    .rd_addr_o  (rd_addr_o),
    .busy_o     (busy_o),
    .cap_o      (cap),
    .fin_o      (fin),
    .idx_o      (idx),
    .base_o     (base),
    .done_o     (done_o)
  );

  desc_fetch_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk        (clk),
    .rst        (rst),
    .cap_i      (cap),
    .fin_i      (fin),
    .idx_i      (idx),
    .data_i     (rsp_data_i),
    .base_i     (base),
    .stage_tsz_o(stage_tsz),
    .more_o     (more_o),
    .flags_o    (flags_o),
    .src_o      (src_addr_o),
    .dst_o      (dst_addr_o),
    .next_o     (next_desc_o),
    .cur_o      (cur_desc_o)
  );

  desc_fetch_size u_size (
    .clk         (clk),
    .rst         (rst),
    .load_i      (fin),
    .load_val_i  (stage_tsz),
    .term_i      (term_i),
    .wb_size_i   (wb_size_i),
    .desc_mode_i (desc_mode_i),
    .words_done_i(words_done_i),
    .size_o      (size_o)
  );

  // R4: completion follows a sampled response
  p_done_after_rsp_r4: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(rsp_valid_i));

  // R4: the fetcher is idle when it reports completion
  p_done_idle_r4: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
endmodule

// File: tb/tb_desc_fetch_top.sv
`timescale 1ns/1ps
module tb_desc_fetch_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [31:0] ptr;
  logic        rd_valid;
  logic [31:0] rd_addr;
  logic        rd_ready;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        busy, done, more;
  logic [3:0]  flags;
  logic [31:0] src, dst, cur, nxt;
  logic [11:0] size;
  logic        term, wb_en, ed_en;
  logic [11:0] wdone;

  desc_fetch_top dut (
    .clk(clk), .rst(rst), .start_i(start), .desc_ptr_i(ptr),
    .rd_valid_o(rd_valid), .rd_addr_o(rd_addr), .rd_ready_i(rd_ready),
    .rsp_valid_i(rsp_valid), .rsp_data_i(rsp_data),
    .busy_o(busy), .done_o(done), .more_o(more), .flags_o(flags),
    .src_addr_o(src), .dst_addr_o(dst), .cur_desc_o(cur), .next_desc_o(nxt),
    .size_o(size), .term_i(term), .wb_size_i(wb_en), .desc_mode_i(ed_en),
    .words_done_i(wdone)
  );

  always #4 clk = ~clk; // 125 MHz

  // Stimulus table: pointer, control word, source, destination, next, latency, stall, inject
  localparam int NV = 6;
  localparam logic [31:0] V_PTR [NV] = '{32'h0000_1000, 32'h0000_1010, 32'h0000_FFF0,
                                         32'hFFFF_FFF0, 32'h8000_0000, 32'h0000_0004};
  localparam logic [31:0] V_CTL [NV] = '{32'h0010_0040, 32'h000F_0FFF, 32'h0015_0001,
                                         32'h000A_0800, 32'hFFEF_FFFF, 32'h0000_0000};
  localparam logic [31:0] V_SRC [NV] = '{32'h2000_0000, 32'h2000_0100, 32'h1234_5678,
                                         32'hA5A5_A5A5, 32'hFFFF_FFFF, 32'h0000_0001};
  localparam logic [31:0] V_DST [NV] = '{32'h3000_0000, 32'h3000_0200, 32'h8765_4321,
                                         32'h5A5A_5A5A, 32'h0000_0000, 32'h0000_0002};
  localparam logic [31:0] V_NXT [NV] = '{32'h0000_1010, 32'h0000_FFF0, 32'hFFFF_FFF0,
                                         32'h8000_0000, 32'h0000_0004, 32'h0000_0000};
  localparam int V_LAT [NV] = '{0, 2, 0, 1, 3, 0};
  localparam int V_STL [NV] = '{0, 0, 3, 1, 2, 0};
  localparam bit V_INJ [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;

  // Memory model state (words set by the bench per vector)
  logic [31:0] m_base, m_w0, m_w1, m_w2, m_w3;
  int          lat_v = 0;
  int          stall_v = 0;
  int          wcnt = 0;
  logic        pend = 1'b0;
  logic [31:0] paddr;
  int          pcnt = 0;
  logic [31:0] acc_addr [16];
  int          acc_n = 0;

  int          last_rsp = 0;
  int          done_n = 0;
  int          mism_n = 0;
  logic [31:0] snap_src, snap_dst, snap_nxt;
  logic [11:0] snap_size;
  logic [3:0]  snap_flags;

  assign rd_ready = (wcnt >= stall_v);

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] off;
    off = a - m_base;
    case (off)
      32'h0:   return m_w0;
      32'h4:   return m_w1;
      32'h8:   return m_w2;
      32'hC:   return m_w3;
      default: return 32'hDEAD_BEEF;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rd_valid && !rd_ready) wcnt <= wcnt + 1;
    else wcnt <= 0;
    rsp_valid <= 1'b0;
    if (rst) begin
      pend <= 1'b0;
    end else begin
      if (pend) begin
        if (pcnt == 0) begin
          rsp_valid <= 1'b1;
          rsp_data  <= mem_word(paddr);
          pend      <= 1'b0;
        end else begin
          pcnt <= pcnt - 1;
        end
      end
      if (rd_valid && rd_ready) begin
        pend  <= 1'b1;
        paddr <= rd_addr;
        pcnt  <= lat_v;
        acc_addr[acc_n % 16] <= rd_addr;
        acc_n <= acc_n + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rsp_valid) last_rsp = cyc;
    if (done) done_n = done_n + 1;
    if (busy && (src !== snap_src || dst !== snap_dst || nxt !== snap_nxt ||
                 size !== snap_size || flags !== snap_flags)) mism_n = mism_n + 1;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
    report();
  end

  task automatic run_fetch(input int i);
    int a0;
    int d0;
    int m0;
    bit got;
    int dcyc;
    logic [31:0] ctl;
    a0 = acc_n; d0 = done_n; m0 = mism_n;
    snap_src = src; snap_dst = dst; snap_nxt = nxt; snap_size = size; snap_flags = flags;
    m_base = V_PTR[i]; m_w0 = V_CTL[i]; m_w1 = V_SRC[i]; m_w2 = V_DST[i]; m_w3 = V_NXT[i];
    lat_v = V_LAT[i]; stall_v = V_STL[i];
    ctl = V_CTL[i];
    ptr = V_PTR[i];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ptr = 32'h5555_0000;
    if (V_INJ[i]) begin
      repeat (2) @(negedge clk);
      check(busy === 1'b1, "R10 busy before injected start", {31'd0, busy}, 32'd1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    got = 1'b0;
    for (int k = 0; k < 300 && !got; k++) begin
      if (done) got = 1'b1;
      else @(negedge clk);
    end
    dcyc = cyc;
    check(got, "R4 done seen", {31'd0, got}, 32'd1);
    check(dcyc == last_rsp + 1, "R4 done one cycle after last response", dcyc, last_rsp + 1);
    check(busy === 1'b0, "R4 idle at done", {31'd0, busy}, 32'd0);
    check(acc_n - a0 == 4, "R2 R10 exactly four reads", acc_n - a0, 32'd4);
    for (int k = 0; k < 4; k++)
      check(acc_addr[(a0 + k) % 16] === V_PTR[i] + 32'(4 * k), "R2 read order/address",
            acc_addr[(a0 + k) % 16], V_PTR[i] + 32'(4 * k));
    check(more === ~ctl[20], "R5 more flag", {31'd0, more}, {31'd0, ~ctl[20]});
    check(flags === ctl[19:16], "R6 flags", {28'd0, flags}, {28'd0, ctl[19:16]});
    check(size === ctl[11:0], "R7 total size", {20'd0, size}, {20'd0, ctl[11:0]});
    check(src === V_SRC[i], "R8 source", src, V_SRC[i]);
    check(dst === V_DST[i], "R8 destination", dst, V_DST[i]);
    check(cur === V_PTR[i], "R9 current descriptor", cur, V_PTR[i]);
    check(nxt === V_NXT[i], "R9 next descriptor", nxt, V_NXT[i]);
    check(mism_n == m0, "R12 fields stable during fetch", mism_n - m0, 32'd0);
    @(negedge clk);
    check(done === 1'b0, "R4 done single cycle", {31'd0, done}, 32'd0);
    check(done_n - d0 == 1, "R4 one done per fetch", done_n - d0, 32'd1);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; ptr = '0; term = 1'b0; wb_en = 1'b0; ed_en = 1'b0; wdone = '0;
    m_base = '0; m_w0 = '0; m_w1 = '0; m_w2 = '0; m_w3 = '0; rsp_data = '0;
    snap_src = '0; snap_dst = '0; snap_nxt = '0; snap_size = '0; snap_flags = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(busy === 1'b0 && done === 1'b0 && rd_valid === 1'b0, "R1 control idle after reset",
          {29'd0, busy, done, rd_valid}, 32'd0);
    check(src === 32'd0 && nxt === 32'd0 && size === 12'd0 && more === 1'b0, "R1 fields zero after reset",
          src | nxt | {20'd0, size} | {31'd0, more}, 32'd0);
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_fetch(i);

    // R11 size write-back
    run_fetch(0); // size = 0x040
    term = 1'b1; wb_en = 1'b1; ed_en = 1'b1; wdone = 12'd21;
    @(negedge clk);
    term = 1'b0;
    check(size === 12'd43, "R11 remaining words written back", {20'd0, size}, 32'd43);
    term = 1'b1; wb_en = 1'b1; ed_en = 1'b0; wdone = 12'd5;
    @(negedge clk);
    term = 1'b0;
    check(size === 12'd43, "R11 no write-back without descriptor mode", {20'd0, size}, 32'd43);
    term = 1'b1; wb_en = 1'b0; ed_en = 1'b1; wdone = 12'd7;
    @(negedge clk);
    term = 1'b0;
    check(size === 12'd43, "R11 no write-back without enable", {20'd0, size}, 32'd43);

    // R1 reset in the middle of a fetch
    m_base = V_PTR[1]; m_w0 = V_CTL[1]; m_w1 = V_SRC[1]; m_w2 = V_DST[1]; m_w3 = V_NXT[1];
    lat_v = 2; stall_v = 0;
    ptr = V_PTR[1]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check(busy === 1'b1, "R1 fetch under way before reset", {31'd0, busy}, 32'd1);
    rst = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && rd_valid === 1'b0 && done === 1'b0, "R1 idle after mid-fetch reset",
          {29'd0, busy, rd_valid, done}, 32'd0);
    check(size === 12'd0 && src === 32'd0, "R1 fields cleared by reset", src | {20'd0, size}, 32'd0);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1 stays idle after reset", {30'd0, busy, done}, 32'd0);

    report();
  end
endmodule